// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames the logical registers named by incoming instructions onto a larger pool of physical registers, for a core in which the physical pool is the only register storage. Each rename request carries two source logical registers and an optional destination. The block translates both sources through a mapping table, hands the destination a fresh physical tag taken from a queue of unused tags, and reports the tag the destination was bound to before this instruction. The response is combinational in the cycle the request is accepted.

A physical register is not reclaimed when the instruction that wrote it retires. It is reclaimed when a later instruction that overwrites the same logical register retires, because by then every reader of the old value has retired. The retire port carries that old tag back, and it joins the tail of the free queue. Logical register 0 is bound permanently to physical tag 0 and never allocates.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical tag i for every i below LREGS, and the free queue holds tags LREGS up to PREGS-1 in ascending order, so the first allocations return LREGS, LREGS+1, and so on.
- R2: Both source tags of a request are read from the table as it stands before the same request's destination update; a request accepted in a later cycle sees the new binding.
- R3: An accepted request with `req_has_dst`=1 and `req_dst`≠0 raises `rsp_alloc`, returns the tag at the head of the free queue on `rsp_new_tag`, returns the destination's previous binding on `rsp_old_tag`, and binds the destination to the new tag from the next cycle on; a logical register written twice receives two different tags.
- R4: A request with `req_has_dst`=0 or `req_dst`=0 allocates nothing: `rsp_alloc`=0, `rsp_new_tag`=0, `rsp_old_tag`=0, the table and free queue are unchanged, and logical register 0 always reads physical tag 0.
- R5: A retire with `ret_valid`=1 appends `ret_tag` to the tail of the free queue; tags leave the queue in the order they entered it.
- R6: `req_ready` is 0 exactly when the request names a real destination (R4 sense) and the free queue is empty; requests without a real destination are always ready.
- R7: A rename and a retire in the same cycle both take effect; a tag retired while the queue is empty is not allocatable in that cycle but is the tag allocated by the next accepted allocating request.
- R8: A retire carrying tag 0 is ignored and does not enter the free queue.
- R9: A tag handed out by an allocation is never one that the table currently maps to any logical register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_src_a | input | LW | First source logical register |
| req_src_b | input | LW | Second source logical register |
| req_has_dst | input | 1 | Request writes a destination |
| req_dst | input | LW | Destination logical register |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_alloc | output | 1 | Accepted request allocated a tag |
| rsp_src_a_tag | output | PW | Physical tag of first source |
| rsp_src_b_tag | output | PW | Physical tag of second source |
| rsp_new_tag | output | PW | Newly allocated destination tag, 0 if none |
| rsp_old_tag | output | PW | Previous binding of the destination, 0 if none |
| ret_valid | input | 1 | Retire returns a tag |
| ret_tag | input | PW | Old physical tag being freed |

## Verification
The two functions that can coincide are allocation from the head of the free queue and release of a retired tag to its tail. The bench drives the queue to empty, then retires a tag in the same cycle as a stalled allocating request, and judges that the request stays stalled in that cycle and receives exactly the retired tag in the next one. Long random runs mix renames with in-order retirement of the reported old tags, so allocation and release land on the same edge many times, with every response compared against a bench model of the table and queue.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Next position in a ring of the given depth.
  function automatic int unsigned ring_next(int unsigned pos, int unsigned depth);
    return (pos + 1 == depth) ? 0 : pos + 1;
  endfunction

  // Tag preloaded into free slot k: the first tag not used by the reset mapping, plus k.
  function automatic int unsigned preload_tag(int unsigned first_free, int unsigned k);
    return first_free + k;
  endfunction

  // Occupancy after one cycle of push and pop.
  function automatic int unsigned next_fill(int unsigned fill, logic push, logic pop);
    return fill + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int DEPTH = 32,
  parameter int BASE  = 32,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [PW-1:0] push_tag_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_tag_o,
  output logic          empty_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] slot [DEPTH];
  logic [IW-1:0] head, tail;
  logic [CW-1:0] fill;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot[k] <= PW'(rn_pkg::preload_tag(BASE, k));
        else if (push_i && tail == IW'(k))
          slot[k] <= push_tag_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      fill <= CW'(DEPTH);
    end else begin
      if (pop_i)  head <= IW'(rn_pkg::ring_next(int'(head), DEPTH));
      if (push_i) tail <= IW'(rn_pkg::ring_next(int'(tail), DEPTH));
      fill <= CW'(rn_pkg::next_fill(int'(fill), push_i, pop_i));
    end
  end

  assign head_tag_o = slot[head];
  assign empty_o    = (fill == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (fill != CW'(DEPTH)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int LREGS = 32,
  parameter int LW    = 5,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_a_idx,
  input  logic [LW-1:0] rd_b_idx,
  input  logic [LW-1:0] rd_d_idx,
  output logic [PW-1:0] rd_a_tag,
  output logic [PW-1:0] rd_b_tag,
  output logic [PW-1:0] rd_d_tag,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] ent [LREGS];

  generate
    for (genvar i = 0; i < LREGS; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n)
          ent[i] <= PW'(i);
        else if (wr_en && wr_idx == LW'(i))
          ent[i] <= wr_tag;
      end
    end
  endgenerate

  assign rd_a_tag = ent[rd_a_idx];
  assign rd_b_tag = ent[rd_b_idx];
  assign rd_d_tag = ent[rd_d_idx];

  // R3
  map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent[$past(wr_idx)] == $past(wr_tag)));

  // R4
  zero_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int LREGS = 32,
  parameter int PREGS = 64,
  localparam int LW = $clog2(LREGS),
  localparam int PW = $clog2(PREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [LW-1:0] req_src_a,
  input  logic [LW-1:0] req_src_b,
  input  logic          req_has_dst,
  input  logic [LW-1:0] req_dst,
  output logic          req_ready,
  output logic          rsp_alloc,
  output logic [PW-1:0] rsp_src_a_tag,
  output logic [PW-1:0] rsp_src_b_tag,
  output logic [PW-1:0] rsp_new_tag,
  output logic [PW-1:0] rsp_old_tag,
  input  logic          ret_valid,
  input  logic [PW-1:0] ret_tag
);
  localparam int FREE_N = PREGS - LREGS;

  // Named internal events for the assertions.
  logic          dst_real;
  logic          fire;
  logic          alloc_ev;
  logic          free_ev;
  logic          fl_empty;
  logic [PW-1:0] fl_head;
  logic [PW-1:0] map_dst_tag;

  assign dst_real  = req_has_dst && (req_dst != '0);
  assign req_ready = !(dst_real && fl_empty);
  assign fire      = req_valid && req_ready;
  assign alloc_ev  = fire && dst_real;
  assign free_ev   = ret_valid && (ret_tag != '0);

  rn_map_table #(.LREGS(LREGS), .LW(LW), .PW(PW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (req_src_a),
    .rd_b_idx (req_src_b),
    .rd_d_idx (req_dst),
    .rd_a_tag (rsp_src_a_tag),
    .rd_b_tag (rsp_src_b_tag),
    .rd_d_tag (map_dst_tag),
    .wr_en    (alloc_ev),
    .wr_idx   (req_dst),
    .wr_tag   (fl_head)
  );

  rn_free_fifo #(.DEPTH(FREE_N), .BASE(LREGS), .PW(PW)) u_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (free_ev),
    .push_tag_i (ret_tag),
    .pop_i      (alloc_ev),
    .head_tag_o (fl_head),
    .empty_o    (fl_empty)
  );

  assign rsp_alloc   = alloc_ev;
  assign rsp_new_tag = alloc_ev ? fl_head : '0;
  assign rsp_old_tag = alloc_ev ? map_dst_tag : '0;

  // R3
  fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |-> (rsp_new_tag != rsp_old_tag));

  // R7
  same_cycle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_ev && fl_empty) |=> !fl_empty);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !free_ev) |=> fl_empty);

endmodule

// File: tb/reg_rename_tb.sv
`timescale 1ns/1ps
module reg_rename_tb;
  localparam int LREGS = 5;
  localparam int PREGS = 12;
  localparam int LW = $clog2(LREGS);
  localparam int PW = $clog2(PREGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_has_dst = 1'b0, ret_valid = 1'b0;
  logic [LW-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic [PW-1:0] ret_tag = '0;
  logic req_ready, rsp_alloc;
  logic [PW-1:0] rsp_src_a_tag, rsp_src_b_tag, rsp_new_tag, rsp_old_tag;

  always #2 clk = ~clk;

  reg_rename #(.LREGS(LREGS), .PREGS(PREGS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_has_dst(req_has_dst), .req_dst(req_dst), .req_ready(req_ready),
    .rsp_alloc(rsp_alloc), .rsp_src_a_tag(rsp_src_a_tag), .rsp_src_b_tag(rsp_src_b_tag),
    .rsp_new_tag(rsp_new_tag), .rsp_old_tag(rsp_old_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag)
  );

  int n_cmp = 0, n_bad = 0;
  int mp [LREGS];
  int fq [$];
  int inflight [$];
  int s_a, s_b, s_new, s_old, s_rdy;

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic bit needs_tag(bit hd, int d);
    return hd && (d != 0);
  endfunction

  function automatic bit is_mapped(int tag);
    for (int k = 0; k < LREGS; k++) if (mp[k] == tag) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: drive, compare against model, clock, update model.
  task automatic cycle(string rq, bit v, int a, int b, bit hd, int d, bit rv, int rt);
    bit need, exp_rdy, go;
    int new_t, old_t;
    @(negedge clk);
    req_valid = v; req_src_a = LW'(a); req_src_b = LW'(b);
    req_has_dst = hd; req_dst = LW'(d);
    ret_valid = rv; ret_tag = PW'(rt);
    #1;
    s_a = int'(rsp_src_a_tag); s_b = int'(rsp_src_b_tag);
    s_new = int'(rsp_new_tag); s_old = int'(rsp_old_tag); s_rdy = int'(req_ready);
    need = needs_tag(hd, d);
    exp_rdy = !(need && fq.size() == 0);
    chk({rq, "/R6"}, "ready", s_rdy, int'(exp_rdy));
    go = v && exp_rdy;
    new_t = 0; old_t = 0;
    if (go) begin
      chk({rq, "/R2"}, "src a tag", s_a, mp[a]);
      chk({rq, "/R2"}, "src b tag", s_b, mp[b]);
      if (need) begin
        new_t = fq[0]; old_t = mp[d];
        chk({rq, "/R3"}, "alloc", int'(rsp_alloc), 1);
        chk({rq, "/R5"}, "new tag", s_new, new_t);
        chk({rq, "/R3"}, "old tag", s_old, old_t);
        chk({rq, "/R9"}, "new tag already mapped", int'(is_mapped(s_new)), 0);
      end else begin
        chk({rq, "/R4"}, "alloc", int'(rsp_alloc), 0);
        chk({rq, "/R4"}, "new tag", s_new, 0);
        chk({rq, "/R4"}, "old tag", s_old, 0);
      end
    end
    @(posedge clk);
    if (go && need) begin
      void'(fq.pop_front());
      inflight.push_back(old_t);
      mp[d] = new_t;
    end
    if (rv && rt != 0) fq.push_back(rt);
  endtask

  task automatic idle();
    cycle("idle", 1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int rt;
    void'($urandom(32'h1d2c3b4a));
    for (int k = 0; k < LREGS; k++) mp[k] = k;
    for (int k = LREGS; k < PREGS; k++) fq.push_back(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset mapping, read through source ports
    for (int r = 0; r < LREGS; r++) begin
      cycle("R1", 1'b1, r, r, 1'b0, 0, 1'b0, 0);
      chk("R1", "reset map", s_a, r);
    end

    // R2/R3: four-instruction example
    cycle("R3", 1'b1, 2, 4, 1'b1, 1, 1'b0, 0);
    chk("R1", "first alloc", s_new, 5);
    cycle("R2", 1'b1, 1, 2, 1'b1, 4, 1'b0, 0);
    chk("R2", "reads new R1", s_a, 5);
    chk("R1", "second alloc", s_new, 6);
    cycle("R2", 1'b1, 1, 3, 1'b1, 3, 1'b0, 0);
    chk("R1", "third alloc", s_new, 7);
    cycle("R3", 1'b1, 3, 2, 1'b1, 1, 1'b0, 0);
    chk("R3", "R1 rewritten gets new tag", s_new, 8);
    chk("R3", "R1 old tag", s_old, 5);
    cycle("R3", 1'b1, 1, 2, 1'b0, 0, 1'b0, 0);
    chk("R3", "map R1", s_a, 8); chk("R3", "map R2", s_b, 2);
    cycle("R3", 1'b1, 3, 4, 1'b0, 0, 1'b0, 0);
    chk("R3", "map R3", s_a, 7); chk("R3", "map R4", s_b, 6);

    // R4: register 0 as destination and as source
    cycle("R4", 1'b1, 0, 1, 1'b1, 0, 1'b0, 0);
    chk("R4", "zero src tag", s_a, 0);

    // R6: exhaust the free queue
    cycle("R6", 1'b1, 1, 1, 1'b1, 1, 1'b0, 0);
    cycle("R6", 1'b1, 2, 2, 1'b1, 2, 1'b0, 0);
    cycle("R6", 1'b1, 3, 3, 1'b1, 3, 1'b0, 0);
    cycle("R6", 1'b1, 1, 2, 1'b1, 4, 1'b0, 0);
    chk("R6", "stalled when empty", s_rdy, 0);
    cycle("R6", 1'b1, 1, 2, 1'b0, 0, 1'b0, 0);
    chk("R6", "no-dst ready when empty", s_rdy, 1);

    // R7: retire while empty in the same cycle as a stalled allocation
    rt = inflight.pop_front();
    cycle("R7", 1'b1, 1, 2, 1'b1, 4, 1'b1, rt);
    chk("R7", "same-cycle stall", s_rdy, 0);
    cycle("R7", 1'b1, 1, 2, 1'b1, 4, 1'b0, 0);
    chk("R7", "retired tag reused", s_new, 1);

    // R8: retire of tag 0 ignored
    cycle("R8", 1'b0, 0, 0, 1'b0, 0, 1'b1, 0);
    cycle("R8", 1'b1, 1, 2, 1'b1, 2, 1'b0, 0);
    chk("R8", "tag 0 not freed", s_rdy, 0);

    // Random mix of renames and in-order retires
    for (int n = 0; n < 4000; n++) begin
      bit v, hd, rv;
      int a, b, d;
      v  = ($urandom_range(3) != 0);
      hd = ($urandom_range(3) != 0);
      a = $urandom_range(LREGS - 1); b = $urandom_range(LREGS - 1);
      d = $urandom_range(LREGS - 1);
      rv = (inflight.size() != 0) && ($urandom_range(1) == 1);
      rt = 0;
      if (rv) rt = inflight.pop_front();
      cycle("rand", v, a, b, hd, d, rv, rt);
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule